// File: doc/BRIEF.md
# Three-Wire Serial Master with Address-Framed Chip Selects

This block is a clocked serial master for simple three-wire peripherals (clock, data out, data in) plus eight active-low select lines. A host reaches it through a small synchronous register port. Two data byte registers are shared by every peripheral. They hold the outgoing bits before a transfer and the received bits after it.

Select lines can be driven in two ways. In software framing the host sets bits in a select register and starts a transfer by writing the first data byte at its plain address. In hardware framing the host writes the first data byte through one of eight alias addresses. The alias picks the select line, and a sequencer lowers that line, runs the transfer and raises the line again. Each peripheral therefore looks like a memory-mapped byte or word. The serial clock comes from the system clock through a programmable divider. An optional active-low interrupt marks the end of each transfer.

Top module: `mwire_master`

## Requirements
- R1: After reset all `cs_n` lines are high, `sk` is low, `irq_n` is high, and the control (0Ah), clock (0Bh), select (0Ch) and status (0Dh) registers read as zero.
- R2: Writing value v to the select register at 0Ch drives `cs_n` to ~v while idle (bit n set pulls `cs_n[n]` low), and 0Ch reads back v.
- R3: A write to 01h loads the first data byte and starts a transfer in which `cs_n` keeps the pattern set from the select register.
- R4: A write to address 02h+n (n = 0..7) loads the first data byte and frames the transfer on `cs_n[n]` alone. That line falls at least one serial clock period before the first rising `sk` edge and rises exactly one period after the last falling edge.
- R5: Control bit 0 selects the length: 0 gives 8 bits (first byte only), 1 gives 16 bits (byte 01h, then byte 00h). Each byte is sent MSB first.
- R6: `si` is sampled on each rising `sk` edge and shifted into the same data registers. Afterwards 01h holds the first received byte and, in 16-bit mode, 00h holds the second.
- R7: With value N in clock register bits 5:0, the `sk` period is 2×(N+1) system clocks, and `sk` rests low when idle.
- R8: `so` changes only while `sk` is low, and it is updated on the falling edge.
- R9: Status bit 0 (busy) reads 1 for the whole transfer. While busy, writes to 00h–09h and 0Ch are ignored.
- R10: When clock register bit 7 is set, `irq_n` goes low at the end of each transfer and stays low until the status register is read. When bit 7 is clear, `irq_n` stays high. Status bit 1 is the completion flag, and reading 0Dh clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; `rdata` is valid the next cycle |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sk | output | 1 | Serial clock |
| so | output | 1 | Serial data to peripherals |
| si | input | 1 | Serial data from peripherals |
| cs_n | output | 8 | Active-low chip selects |
| irq_n | output | 1 | Active-low end-of-transfer interrupt |

## Verification
A wrong sequencer state shows up at the pins within one serial clock period. Possible symptoms are a select line that drops on the wrong index, a bit count other than 8 or 16 on `sk`, or a select that is released too early around the first or last edge. A fault in the divider or shifter shows up as wrong edge spacing on `sk`, or as wrong bytes on `so` and in the readback registers after completion. A bookkeeping error in the busy or completion logic shows up as a second, unrequested frame, as overwritten data after an ignored write, or as an interrupt that does not hold or does not clear.

// File: rtl/mwire_pkg.sv
`timescale 1ns/1ps
package mwire_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_BYTE2  = 4'h0;
  localparam logic [ADDR_W-1:0] A_BYTE1  = 4'h1;
  localparam logic [ADDR_W-1:0] A_ALIAS0 = 4'h2;
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'hA;
  localparam logic [ADDR_W-1:0] A_CLKDIV = 4'hB;
  localparam logic [ADDR_W-1:0] A_SELECT = 4'hC;
  localparam logic [ADDR_W-1:0] A_STATUS = 4'hD;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD
  } seq_state_t;
endpackage

// File: rtl/mwire_clkdiv.sv
`timescale 1ns/1ps
module mwire_clkdiv #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] ratio,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt >= ratio) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // one tick per half period of the serial clock
  assign tick = run && (cnt >= ratio);
endmodule

// File: rtl/mwire_shifter.sv
`timescale 1ns/1ps
module mwire_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_first,
  input  logic          wr_second,
  input  logic [DW-1:0] wdata,
  input  logic          sample,
  input  logic          shift,
  input  logic          len16,
  input  logic          si,
  output logic [DW-1:0] first_q,
  output logic [DW-1:0] second_q,
  output logic          so
);
  logic rx_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      second_q <= '0;
      rx_bit   <= 1'b0;
    end else begin
      if (sample) rx_bit <= si;
      if (shift) begin
        if (len16) {first_q, second_q} <= {first_q[DW-2:0], second_q, rx_bit};
        else       first_q <= {first_q[DW-2:0], rx_bit};
      end else begin
        if (wr_first)  first_q  <= wdata;
        if (wr_second) second_q <= wdata;
      end
    end
  end

  assign so = first_q[DW-1];
endmodule

// File: rtl/mwire_seq.sv
`timescale 1ns/1ps
module mwire_seq
  import mwire_pkg::*;
#(
  parameter int CS_N = 8,
  parameter int TW   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            start,
  input  logic            auto_sel,
  input  logic [TW-1:0]   target,
  input  logic            len16,
  input  logic [CS_N-1:0] cs_sw,
  output logic            busy,
  output logic            sk,
  output logic            len_q,
  output logic            done_pulse,
  output logic            sample,
  output logic            shift,
  output logic [CS_N-1:0] cs_n
);
  seq_state_t state;
  logic       ph;
  logic [3:0] bitcnt;
  logic [3:0] last_bit;
  logic [CS_N-1:0] sel_vec;

  for (genvar g = 0; g < CS_N; g++) begin : g_sel
    assign sel_vec[g] = (target == TW'(g));
  end

  assign last_bit = len_q ? 4'd15 : 4'd7;
  assign sample   = tick && (state == ST_SHIFT) && !sk;
  assign shift    = tick && (state == ST_SHIFT) && sk;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ph         <= 1'b0;
      bitcnt     <= '0;
      busy       <= 1'b0;
      sk         <= 1'b0;
      len_q      <= 1'b0;
      done_pulse <= 1'b0;
      cs_n       <= '1;
    end else begin
      done_pulse <= 1'b0;
      case (state)
        ST_IDLE: begin
          cs_n <= ~cs_sw;
          if (start) begin
            state  <= ST_SETUP;
            busy   <= 1'b1;
            ph     <= 1'b0;
            bitcnt <= '0;
            len_q  <= len16;
            if (auto_sel) cs_n <= ~sel_vec;
          end
        end
        ST_SETUP: if (tick) begin
          ph <= ~ph;
          if (ph) state <= ST_SHIFT;
        end
        ST_SHIFT: if (tick) begin
          sk <= ~sk;
          if (sk) begin
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == last_bit) begin
              state <= ST_HOLD;
              ph    <= 1'b0;
            end
          end
        end
        ST_HOLD: if (tick) begin
          ph <= ~ph;
          if (ph) begin
            state      <= ST_IDLE;
            busy       <= 1'b0;
            done_pulse <= 1'b1;
            cs_n       <= ~cs_sw;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_CS_FRAME_STABLE: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cs_n)); // R4
  AST_SK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sk); // R7
  AST_BITCNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT) |-> (bitcnt <= last_bit)); // R5
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> ($past(busy) && !busy)); // R9
endmodule

// File: rtl/mwire_master.sv
`timescale 1ns/1ps
module mwire_master
  import mwire_pkg::*;
#(
  parameter int CS_N  = 8,
  parameter int DIV_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sk,
  output logic              so,
  input  logic              si,
  output logic [CS_N-1:0]   cs_n,
  output logic              irq_n
);
  localparam int TW = (CS_N > 1) ? $clog2(CS_N) : 1;
  localparam logic [ADDR_W-1:0] A_ALIAS_LAST = A_ALIAS0 + ADDR_W'(CS_N - 1);

  logic              len16_cfg, ien, done, busy, len_q, done_pulse;
  logic              sample, shift, tick;
  logic [DIV_W-1:0]  div_n;
  logic [CS_N-1:0]   cs_sw;
  logic [DATA_W-1:0] first_q, second_q;
  logic              data_wr, alias_hit, start, wr_first, wr_second;
  logic [TW-1:0]     target;

  assign data_wr   = wr_en && !busy;
  assign alias_hit = (addr >= A_ALIAS0) && (addr <= A_ALIAS_LAST);
  assign start     = data_wr && (alias_hit || addr == A_BYTE1);
  assign wr_first  = start;
  assign wr_second = data_wr && (addr == A_BYTE2);
  assign target    = TW'(addr - A_ALIAS0);

  always_ff @(posedge clk) begin
    if (rst) begin
      len16_cfg <= 1'b0;
      ien       <= 1'b0;
      div_n     <= '0;
      cs_sw     <= '0;
      done      <= 1'b0;
      irq_n     <= 1'b1;
      rdata     <= '0;
    end else begin
      if (wr_en && addr == A_CTRL) len16_cfg <= wdata[0];
      if (wr_en && addr == A_CLKDIV) begin
        div_n <= wdata[DIV_W-1:0];
        ien   <= wdata[DATA_W-1];
      end
      if (data_wr && addr == A_SELECT) cs_sw <= wdata[CS_N-1:0];
      if (done_pulse) done <= 1'b1;
      else if (rd_en && addr == A_STATUS) done <= 1'b0;
      irq_n <= ~(done && ien);
      if (rd_en) begin
        rdata <= '0;
        if (addr == A_BYTE2) rdata <= second_q;
        else if (addr == A_BYTE1 || alias_hit) rdata <= first_q;
        else if (addr == A_CTRL) rdata[0] <= len16_cfg;
        else if (addr == A_CLKDIV) begin
          rdata[DIV_W-1:0] <= div_n;
          rdata[DATA_W-1]  <= ien;
        end
        else if (addr == A_SELECT) rdata[CS_N-1:0] <= cs_sw;
        else if (addr == A_STATUS) rdata[1:0] <= {done, busy};
      end
    end
  end

  mwire_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .run(busy), .ratio(div_n), .tick(tick)
  );

  mwire_seq #(.CS_N(CS_N), .TW(TW)) u_seq (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .auto_sel(alias_hit),
    .target(target), .len16(len16_cfg), .cs_sw(cs_sw), .busy(busy), .sk(sk),
    .len_q(len_q), .done_pulse(done_pulse), .sample(sample), .shift(shift),
    .cs_n(cs_n)
  );

  mwire_shifter #(.DW(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .wr_first(wr_first), .wr_second(wr_second),
    .wdata(wdata), .sample(sample), .shift(shift), .len16(len_q), .si(si),
    .first_q(first_q), .second_q(second_q), .so(so)
  );

  AST_SO_STABLE_SK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sk && $past(sk)) |-> $stable(so)); // R8
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    !irq_n |-> $past(ien)); // R10
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && wr_en && addr == A_SELECT) |=> $stable(cs_sw)); // R9
endmodule

// File: tb/mwire_master_bench.sv
`timescale 1ns/1ps
module mwire_master_bench;
  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0, si = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, cs_n;
  logic sk, so, irq_n;

  int checks = 0, errors = 0;

  typedef struct {
    logic [7:0]  cs_exp;
    int          nbits;
    logic [15:0] mosi;
    int          per;
    bit          hw;
  } item_t;
  item_t exp_q[$];

  // slave model state
  int bits_seen = 0, idx = 16;
  logic [15:0] mosi_sh = '0, miso_pat = '0;
  logic [7:0] cs_first = '1, cs_prev = '1;
  realtime t_r1, t_r2, t_lastfall, t_csl, t_csh;

  always #2.5 clk = ~clk;  // 200 MHz

  mwire_master u_mwire_master (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sk(sk), .so(so), .si(si), .cs_n(cs_n),
    .irq_n(irq_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic prep(logic [15:0] m);
    bits_seen = 0; mosi_sh = '0; miso_pat = m; si = m[15]; idx = 1;
  endtask

  task automatic push(logic [7:0] cs_e, int nb, logic [15:0] mo, int n, bit hw);
    item_t it;
    it.cs_exp = cs_e; it.nbits = nb; it.mosi = mo; it.per = 2 * (n + 1); it.hw = hw;
    exp_q.push_back(it);
  endtask

  task automatic clocks(int n);
    repeat (n) @(negedge clk);
  endtask

  // slave: capture on rising sk, present next bit after falling sk
  always @(posedge sk) begin
    if (bits_seen == 0) begin cs_first = cs_n; t_r1 = $realtime; end
    if (bits_seen == 1) t_r2 = $realtime;
    mosi_sh = {mosi_sh[14:0], so};
    bits_seen++;
  end
  always @(negedge sk) begin
    t_lastfall = $realtime;
    if (idx < 16) begin si = miso_pat[15-idx]; idx++; end
  end
  always @(cs_n) begin
    if (cs_n != 8'hFF && cs_prev == 8'hFF) t_csl = $realtime;
    if (cs_n == 8'hFF && cs_prev != 8'hFF) t_csh = $realtime;
    cs_prev = cs_n;
  end

  // monitor: pop expected frame on each interrupt
  always @(negedge irq_n) begin
    if (exp_q.size() == 0) begin
      checks++; errors++;
      $display("FAIL R10: actual unexpected interrupt expected none");
    end else begin
      item_t it;
      it = exp_q.pop_front();
      check("R5 bit count", bits_seen, it.nbits);
      check("R5 serial out data", (it.nbits == 16) ? mosi_sh : {8'h00, mosi_sh[7:0]}, it.mosi);
      check(it.hw ? "R4 select line in frame" : "R3 select pattern in frame", cs_first, it.cs_exp);
      check("R7 sk period", int'((t_r2 - t_r1) / 5.0), it.per);
      if (it.hw) begin
        check("R4 select setup", int'((t_r1 - t_csl) / 5.0) >= it.per, 1);
        check("R4 select hold", int'((t_csh - t_lastfall) / 5.0), it.per);
      end
    end
  end

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    clocks(3); rst = 1'b0; clocks(1);
    // R1 reset state
    check("R1 cs_n", cs_n, 8'hFF);
    check("R1 sk", sk, 0);
    check("R1 irq_n", irq_n, 1);
    rd(4'hA, r); check("R1 ctrl", r, 0);
    rd(4'hB, r); check("R1 clkdiv", r, 0);
    rd(4'hC, r); check("R1 select", r, 0);
    rd(4'hD, r); check("R1 status", r, 0);

    // R2 software select
    wr(4'hC, 8'hA5); clocks(1);
    check("R2 cs_n follows select", cs_n, 8'h5A);
    rd(4'hC, r); check("R2 select readback", r, 8'hA5);

    // R3 software-framed 8-bit transfer, N=1, interrupt on
    wr(4'hC, 8'h10);
    wr(4'hB, 8'h81);
    wr(4'hA, 8'h00);
    prep(16'h5A00);
    push(8'hEF, 8, 16'h00C3, 1, 0);
    wr(4'h1, 8'hC3);
    rd(4'hD, r); check("R9 busy during transfer", r, 8'h01);
    @(negedge irq_n); clocks(10);
    check("R10 irq held until status read", irq_n, 0);
    rd(4'hD, r); check("R10 status done flag", r, 8'h02);
    clocks(1);
    check("R10 irq cleared by status read", irq_n, 1);
    rd(4'h1, r); check("R6 received byte 8-bit", r, 8'h5A);
    check("R3 select kept after frame", cs_n, 8'hEF);

    // R4 hardware-framed 8-bit on line 3, writes while busy ignored
    wr(4'hC, 8'h00);
    wr(4'h0, 8'h11);
    prep(16'h3C00);
    push(8'hF7, 8, 16'h0096, 1, 1);
    wr(4'h5, 8'h96);
    wr(4'h2, 8'hFF);
    wr(4'h0, 8'h77);
    wr(4'hC, 8'hFF);
    @(negedge irq_n); clocks(2);
    rd(4'hD, r); check("R10 status after hw frame", r, 8'h02);
    clocks(100);
    check("R9 no extra frame started", exp_q.size(), 0);
    check("R9 select write ignored", cs_n, 8'hFF);
    rd(4'hC, r); check("R9 select reg unchanged", r, 8'h00);
    rd(4'h0, r); check("R9 second byte unchanged", r, 8'h11);
    rd(4'h1, r); check("R6 received first byte", r, 8'h3C);

    // R5 hardware-framed 16-bit on line 7, N=3
    wr(4'hB, 8'h83);
    wr(4'hA, 8'h01);
    wr(4'h0, 8'h34);
    prep(16'hBEEF);
    push(8'h7F, 16, 16'h1234, 3, 1);
    wr(4'h9, 8'h12);
    @(negedge irq_n); clocks(2);
    rd(4'hD, r);
    rd(4'h1, r); check("R6 16-bit first byte", r, 8'hBE);
    rd(4'h0, r); check("R6 16-bit second byte", r, 8'hEF);

    // R10 interrupt disabled, N=0, 16-bit on line 0
    wr(4'hB, 8'h00);
    wr(4'h0, 8'hA0);
    prep(16'h0FF0);
    wr(4'h2, 8'h5B);
    for (int k = 0; k < 200; k++) begin
      rd(4'hD, r);
      if (r[0] == 1'b0) break;
    end
    check("R10 irq stays high when disabled", irq_n, 1);
    check("R4 line 0 framed", cs_first, 8'hFE);
    check("R5 16-bit order out", mosi_sh, 16'h5BA0);
    check("R7 sk period N=0", int'((t_r2 - t_r1) / 5.0), 2);
    rd(4'h1, r); check("R6 first byte N=0", r, 8'h0F);
    rd(4'h0, r); check("R6 second byte N=0", r, 8'hF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule